// File: doc/BRIEF.md
# Vector Half Interleave Permute Unit

This unit builds a destination vector by pairing elements taken from the same half of two source vectors. The caller picks the lower or the upper half. The chosen half of source A and the chosen half of source B are then merged in alternation: element 0 comes from A, element 1 from B, element 2 from A, and so on. The vector length is given at run time in bits. It must be a multiple of 128 and can go up to the `MAX_VL` parameter. Elements can be 8, 16, 32, 64 or 128 bits wide. There is no predication, so every computed element is written.

A request is accepted whenever `in_valid` is high. The registered result appears one clock later, with `out_valid` high. Some configurations cannot be executed. For these the unit returns an all-zero vector and raises `illegal` in the same cycle as `out_valid`.

Top module: `vhi_permute`

## Requirements
- R1: The element width is 8 << `size_code` (00=8, 01=16, 10=32, 11=64 bits). When `quad_mode`=1 the width is 128 bits and `size_code` has no effect.
- R2: When `upper_half`=0, result element 2p equals `src_a` element p and result element 2p+1 equals `src_b` element p, for 0 <= p < pairs. Here pairs = `vlen` / (2 × width), using integer division, and element i occupies bits [i·width +: width].
- R3: When `upper_half`=1, result element 2p equals `src_a` element pairs+p and result element 2p+1 equals `src_b` element pairs+p.
- R4: Every result bit at or above 2 × pairs × width is zero. This includes the trailing 128 bits in 128-bit mode when `vlen` is an odd multiple of 128.
- R5: A request with `vlen` < 2 × width is illegal. In particular, 128-bit mode needs `vlen` >= 256.
- R6: A request with `vlen` equal to zero, not a multiple of 128, or greater than `MAX_VL` is illegal.
- R7: An illegal request produces `illegal`=1 and an all-zero `result` in its output cycle. A legal request produces `illegal`=0.
- R8: `out_valid` is `in_valid` delayed by exactly one clock. `result` and `illegal` change only on cycles that follow an accepted request, and otherwise hold their values.
- R9: Synchronous active-high `rst` clears `out_valid`, `illegal` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | MAX_VL | First source vector |
| src_b | input | MAX_VL | Second source vector |
| vlen | input | VLW | Active vector length in bits |
| size_code | input | 2 | Element width code for widths of 64 bits and below |
| quad_mode | input | 1 | Selects 128-bit elements |
| upper_half | input | 1 | 0 takes the lower halves, 1 takes the upper halves |
| out_valid | output | 1 | Result strobe |
| illegal | output | 1 | Request configuration could not be executed |
| result | output | MAX_VL | Interleaved destination vector |

## Verification
The assertions assume that `vlen`, `quad_mode` and `in_valid` keep one value for the whole cycle in which they are sampled. The zero-above-length property compares the result against the `vlen` presented in the previous cycle. The bench therefore changes inputs only on the falling clock edge and holds each request stable through the next rising edge. All stimulus uses widths that fit `VLW`: legal lengths of 128 to `MAX_VL`, and illegal values such as 0, non-multiples of 128, and a value above `MAX_VL`.

// File: rtl/vhi_pkg.sv
package vhi_pkg;
    localparam int LANE_BITS = 128;
    localparam int NUM_WIDTHS = 5;

    typedef enum logic [2:0] {
        EW8   = 3'd0,
        EW16  = 3'd1,
        EW32  = 3'd2,
        EW64  = 3'd3,
        EW128 = 3'd4
    } elem_w_e;
endpackage

// File: rtl/vhi_len_check.sv
module vhi_len_check #(
    parameter int MAX_VL = 512,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic [VLW-1:0]      vlen,
    input  vhi_pkg::elem_w_e    ew,
    output logic                bad
);
    localparam int LSB_W = $clog2(vhi_pkg::LANE_BITS);

    logic [VLW-1:0] min_len;
    logic           not_lane_mult;
    logic           too_long;
    logic           too_short;

    always_comb begin
        min_len       = VLW'(16) << ew;
        not_lane_mult = (vlen[LSB_W-1:0] != '0);
        too_long      = (vlen > VLW'(MAX_VL));
        too_short     = (vlen < min_len);
        bad           = (vlen == '0) | not_lane_mult | too_long | too_short;
    end
endmodule

// File: rtl/vhi_interleave.sv
module vhi_interleave #(
    parameter int MAX_VL = 512,
    parameter int VLW    = $clog2(MAX_VL) + 1,
    parameter int ESIZE  = 8
) (
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    input  logic [VLW-1:0]    vlen,
    input  logic              upper_half,
    output logic [MAX_VL-1:0] res
);
    localparam int NE = MAX_VL / ESIZE;
    localparam int SH = $clog2(2 * ESIZE);
    localparam int IW = $clog2(NE) + 1;

    logic [VLW-1:0] pairs_full;
    logic [IW-1:0]  pairs;
    logic [IW-1:0]  base;

    assign pairs_full = vlen >> SH;
    assign pairs      = pairs_full[IW-1:0];
    assign base       = upper_half ? pairs : '0;

    for (genvar k = 0; k < NE; k++) begin : g_elem
        localparam int P = k / 2;
        logic [IW-1:0]    idx;
        logic             take;
        logic [ESIZE-1:0] pick;

        assign idx  = base + IW'(P);
        assign take = (IW'(P) < pairs) && (idx < IW'(NE));
        if ((k % 2) == 0) begin : g_even
            assign pick = src_a[idx*ESIZE +: ESIZE];
        end else begin : g_odd
            assign pick = src_b[idx*ESIZE +: ESIZE];
        end
        assign res[k*ESIZE +: ESIZE] = take ? pick : '0;
    end
endmodule

// File: rtl/vhi_permute.sv
module vhi_permute #(
    parameter int MAX_VL = 512,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    input  logic [VLW-1:0]    vlen,
    input  logic [1:0]        size_code,
    input  logic              quad_mode,
    input  logic              upper_half,
    output logic              out_valid,
    output logic              illegal,
    output logic [MAX_VL-1:0] result
);
    import vhi_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              bad;
        logic [MAX_VL-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;
    elem_w_e ew;
    logic    cfg_bad;
    logic [MAX_VL-1:0] lane_res [NUM_WIDTHS];

    assign ew = quad_mode ? EW128 : elem_w_e'({1'b0, size_code});

    vhi_len_check #(.MAX_VL(MAX_VL), .VLW(VLW)) len_i (
        .vlen (vlen),
        .ew   (ew),
        .bad  (cfg_bad)
    );

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        vhi_interleave #(.MAX_VL(MAX_VL), .VLW(VLW), .ESIZE(8 << g)) ilv_i (
            .src_a      (src_a),
            .src_b      (src_b),
            .vlen       (vlen),
            .upper_half (upper_half),
            .res        (lane_res[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.bad  = cfg_bad;
            st_d.data = cfg_bad ? '0 : lane_res[int'(ew)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign illegal   = st_q.bad;
    assign result    = st_q.data;
endmodule

// File: rtl/vhi_permute_chk.sv
module vhi_permute_chk #(
    parameter int MAX_VL = 512,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [VLW-1:0]    vlen,
    input logic              quad_mode,
    input logic              out_valid,
    input logic              illegal,
    input logic [MAX_VL-1:0] result
);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (result == '0));
    // R6
    odd_len_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (vlen[6:0] != 7'd0)) |=> illegal);
    // R5
    quad_short_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && quad_mode && (vlen < VLW'(256))) |=> illegal);
    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((result >> $past(vlen)) == '0));
endmodule

bind vhi_permute vhi_permute_chk #(.MAX_VL(MAX_VL), .VLW(VLW)) chk_i (.*);

// File: tb/vhi_permute_tb.sv
module vhi_permute_tb_top;
    localparam int MAX_VL = 512;
    localparam int VLW    = $clog2(MAX_VL) + 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [MAX_VL-1:0] src_a, src_b;
    logic [VLW-1:0]    vlen;
    logic [1:0]        size_code;
    logic              quad_mode, upper_half;
    logic              out_valid, illegal;
    logic [MAX_VL-1:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vhi_permute #(.MAX_VL(MAX_VL)) dut_i (.*);

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [MAX_VL-1:0] act, logic [MAX_VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s result actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [MAX_VL-1:0] rand_vec();
        logic [MAX_VL-1:0] v;
        for (int w = 0; w < MAX_VL / 32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic model(input logic [MAX_VL-1:0] a, input logic [MAX_VL-1:0] b,
                         input int vl, input int sz, input bit q, input bit hi,
                         output logic [MAX_VL-1:0] res, output bit bad);
        int es, pairs, base;
        es  = q ? 128 : (8 << sz);
        res = '0;
        bad = (vl == 0) || (vl % 128 != 0) || (vl > MAX_VL) || (vl < 2 * es);
        if (!bad) begin
            pairs = vl / (2 * es);
            base  = hi ? pairs : 0;
            for (int p = 0; p < pairs; p++)
                for (int i = 0; i < es; i++) begin
                    res[(2*p)*es + i]   = a[(base+p)*es + i];
                    res[(2*p+1)*es + i] = b[(base+p)*es + i];
                end
        end
    endtask

    task automatic run_op(string tag, int vl, int sz, bit q, bit hi);
        logic [MAX_VL-1:0] a, b, exp;
        bit bad;
        a = rand_vec();
        b = rand_vec();
        model(a, b, vl, sz, q, hi, exp, bad);
        @(negedge clk);
        in_valid   = 1'b1;
        src_a      = a;
        src_b      = b;
        vlen       = VLW'(vl);
        size_code  = 2'(sz);
        quad_mode  = q;
        upper_half = hi;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit(tag, "out_valid", out_valid, 1'b1);
        check_bit(tag, "illegal", illegal, bad);
        check_vec(tag, result, exp);
    endtask

    task automatic idle_check();
        logic [MAX_VL-1:0] prev;
        logic prev_ill;
        prev = result;
        prev_ill = illegal;
        src_a = rand_vec();
        vlen  = VLW'(3);
        @(negedge clk);
        check_bit("R8", "out_valid idle", out_valid, 1'b0);
        check_bit("R8", "illegal hold", illegal, prev_ill);
        check_vec("R8", result, prev);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; vlen = '0;
        size_code = '0; quad_mode = 1'b0; upper_half = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R9", "out_valid reset", out_valid, 1'b0);
        check_bit("R9", "illegal reset", illegal, 1'b0);
        check_vec("R9", result, '0);
        rst = 1'b0;

        for (int sz = 0; sz < 5; sz++)
            for (int hi = 0; hi < 2; hi++)
                for (int vl = 128; vl <= MAX_VL; vl += 128)
                    run_op(hi != 0 ? "R3" : "R2", vl, sz % 4, sz == 4, hi != 0);

        run_op("R1", 512, 1, 1'b1, 1'b0);
        run_op("R1", 256, 3, 1'b1, 1'b1);
        run_op("R4", 384, 0, 1'b1, 1'b0);
        run_op("R4", 384, 0, 1'b1, 1'b1);
        run_op("R5", 128, 2, 1'b1, 1'b0);
        run_op("R5", 128, 3, 1'b0, 1'b1);
        run_op("R6", 0, 0, 1'b0, 1'b0);
        run_op("R6", 200, 1, 1'b0, 1'b0);
        run_op("R6", 640, 2, 1'b0, 1'b1);
        run_op("R7", 100, 3, 1'b1, 1'b1);
        idle_check();
        run_op("R2", 256, 0, 1'b0, 1'b0);
        idle_check();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule